// File: doc/BRIEF.md
# Cache Miss Event Address Capture

This block records where and how slowly cache misses happen, so that a sampling profiler can attribute them. Each completed access arrives on a one-cycle miss-completion interface. The interface carries a kind flag (data or instruction), a hit flag, the bundle address and slot of the instruction responsible, the data address, and the measured latency in cycles. Hits are discarded. A miss is then compared with a minimum-latency threshold, and each channel picks its own threshold from a small code. A miss that passes overwrites that channel's capture registers and raises a one-cycle qualified-event pulse, which feeds an external sampling counter.

There are two independent channels, each with its own registers and its own enable. The data channel keeps the data address, the saturated latency, and a packed instruction-address word. That word holds the bundle address, the slot and a valid bit. The instruction channel keeps the missing cache-line address, with a valid bit in its low bits, and the latency. A data miss and an instruction miss never disturb each other's records. Software can clear either valid bit with a one-cycle clear strobe.

Top module: `miss_addr_capture`

## Requirements
- R1: While rstN is low, and on the first clock edge after rstN rises, every capture output reads zero and both event pulses are low.
- R2: A completion with missIsHit=1 is never captured, and neither is a miss whose channel enable is low. In either case the outputs of both channels keep their values and no event pulse is raised.
- R3: A threshold code sel from 1 to 11 selects a minimum latency of 2^(sel+1) cycles: 1 is 4 and 11 is 4096. A code from 12 to 15 also means 4096. A miss qualifies when its latency is greater than or equal to the minimum.
- R4: Threshold code 0 accepts any latency, including 0.
- R5: For a qualifying miss with missKind=0 (data), the data address, the latency and the instruction-address word all change on the same clock edge that samples missValid. These registers are dataAddr, dataLat and dataIp.
- R6: The instruction-address word has this layout: bits [ADDR_W-1:4] are the bundle address, with the low 4 bits of missInstAddr ignored. Bits [3:2] are the slot number (0 to 2), bit 1 is zero, and bit 0 is the valid flag.
- R7: For a qualifying miss with missKind=1 (instruction), two registers update. The first is instLine: bits [ADDR_W-1:LINE_OFF] hold the line address taken from missInstAddr, bits [LINE_OFF-1:1] are zero, and bit 0 is the valid flag. The second is instLat. No data-channel output changes.
- R8: dataEvent or instEvent is high for exactly one cycle, namely the cycle after the edge that captures a qualifying miss of that kind. It is low otherwise.
- R9: A later qualifying miss of the same kind overwrites every field of the earlier record.
- R10: A high clrData (or clrInst) clears the valid bit of that channel at the next edge and leaves its other fields unchanged. A capture on the same edge takes precedence and leaves the valid bit set.
- R11: A latency above 2^LAT_W-1 is stored as 2^LAT_W-1 (4095 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | One completion is presented this cycle |
| missIsHit | input | 1 | Completion hit in the cache |
| missKind | input | 1 | 0 = data access, 1 = instruction fetch |
| missInstAddr | input | ADDR_W | Bundle address (data) or fetch address (instruction) |
| missSlot | input | 2 | Slot of the instruction in its bundle |
| missDataAddr | input | ADDR_W | Data address of the access |
| missLatency | input | MEAS_W | Measured latency in cycles |
| dataCapEn | input | 1 | Enables the data channel |
| instCapEn | input | 1 | Enables the instruction channel |
| dataThrSel | input | 4 | Data channel threshold code |
| instThrSel | input | 4 | Instruction channel threshold code |
| clrData | input | 1 | Clears the data channel valid bit |
| clrInst | input | 1 | Clears the instruction channel valid bit |
| dataAddr | output | ADDR_W | Captured data address |
| dataLat | output | LAT_W | Captured data-miss latency |
| dataIp | output | ADDR_W | Bundle address, slot and valid flag |
| instLine | output | ADDR_W | Captured line address with valid flag |
| instLat | output | LAT_W | Captured instruction-miss latency |
| dataEvent | output | 1 | Qualified data miss pulse |
| instEvent | output | 1 | Qualified instruction miss pulse |

## Verification
A wrong qualification decision shows in the cycle right after the miss, in two ways at once: the event pulse appears or does not, and the capture registers either take the new record or keep the old one. A threshold decode that is off by one code is caught only by latencies just below and exactly at a power of two, so the stimulus straddles those edges. A corrupted valid flag, or cross-talk between the two channels, stays hidden until a later read. For that reason every output of both channels is compared after every stimulus, against a model that holds the last record expected on each channel.

// File: rtl/miss_cap_pkg.sv
package miss_cap_pkg;

  localparam int unsigned THR_W = 4;
  localparam int unsigned MAX_CODE = 11;

  typedef struct packed {
    logic capData;
    logic capInst;
    logic clrData;
    logic clrInst;
  } mcap_strobe_t;

  function automatic int unsigned thrValue(input logic [THR_W-1:0] sel);
    int unsigned result;
    if (sel == '0) begin
      result = 0;
    end else if (32'(sel) > MAX_CODE) begin
      result = 32'd1 << (MAX_CODE + 1);
    end else begin
      result = 32'd1 << (32'(sel) + 1);
    end
    return result;
  endfunction

endpackage

// File: rtl/mcap_ctrl.sv
module mcap_ctrl
  import miss_cap_pkg::*;
#(
  parameter int unsigned MEAS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic              missIsHit,
  input  logic              missKind,
  input  logic [MEAS_W-1:0] missLatency,
  input  logic              dataCapEn,
  input  logic              instCapEn,
  input  logic [THR_W-1:0]  dataThrSel,
  input  logic [THR_W-1:0]  instThrSel,
  input  logic              clrData,
  input  logic              clrInst,
  output mcap_strobe_t      strobe,
  output logic              dataEvent,
  output logic              instEvent
);

  localparam int unsigned NUM_CH = 2;

  logic [NUM_CH-1:0] qual;
  logic [NUM_CH-1:0] eventQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [THR_W-1:0] sel;
    logic             chanEn;
    logic             kindMatch;
    logic             latOk;

    assign sel       = (ch == 0) ? dataThrSel : instThrSel;
    assign chanEn    = (ch == 0) ? dataCapEn : instCapEn;
    assign kindMatch = (missKind == 1'(ch));
    assign latOk     = 32'(missLatency) >= thrValue(sel);
    assign qual[ch]  = missValid & ~missIsHit & kindMatch & chanEn & latOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        eventQ[ch] <= 1'b0;
      end else begin
        eventQ[ch] <= qual[ch];
      end
    end
  end

  always_comb begin
    strobe.capData = qual[0];
    strobe.capInst = qual[1];
    strobe.clrData = clrData;
    strobe.clrInst = clrInst;
  end

  assign dataEvent = eventQ[0];
  assign instEvent = eventQ[1];

endmodule

// File: rtl/mcap_datapath.sv
module mcap_datapath
  import miss_cap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned MEAS_W   = 16,
  parameter int unsigned LAT_W    = 12,
  parameter int unsigned LINE_OFF = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  mcap_strobe_t      strobe,
  input  logic [ADDR_W-1:0] missInstAddr,
  input  logic [1:0]        missSlot,
  input  logic [ADDR_W-1:0] missDataAddr,
  input  logic [MEAS_W-1:0] missLatency,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [LAT_W-1:0]  dataLat,
  output logic [ADDR_W-1:0] dataIp,
  output logic [ADDR_W-1:0] instLine,
  output logic [LAT_W-1:0]  instLat
);

  localparam int unsigned BUNDLE_OFF = 4;
  localparam int unsigned BUNDLE_W   = ADDR_W - BUNDLE_OFF;
  localparam int unsigned LINE_W     = ADDR_W - LINE_OFF;
  localparam logic [LAT_W-1:0] LAT_MAX = '1;

  logic [LAT_W-1:0]    latSat;
  logic [ADDR_W-1:0]   dAddrQ;
  logic [LAT_W-1:0]    dLatQ;
  logic [BUNDLE_W-1:0] dBundleQ;
  logic [1:0]          dSlotQ;
  logic                dValidQ;
  logic [LINE_W-1:0]   iLineQ;
  logic [LAT_W-1:0]    iLatQ;
  logic                iValidQ;

  always_comb begin
    if (missLatency > MEAS_W'(LAT_MAX)) begin
      latSat = LAT_MAX;
    end else begin
      latSat = missLatency[LAT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dAddrQ   <= '0;
      dLatQ    <= '0;
      dBundleQ <= '0;
      dSlotQ   <= '0;
      dValidQ  <= 1'b0;
    end else if (strobe.capData) begin
      dAddrQ   <= missDataAddr;
      dLatQ    <= latSat;
      dBundleQ <= missInstAddr[ADDR_W-1:BUNDLE_OFF];
      dSlotQ   <= missSlot;
      dValidQ  <= 1'b1;
    end else if (strobe.clrData) begin
      dValidQ  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iLineQ  <= '0;
      iLatQ   <= '0;
      iValidQ <= 1'b0;
    end else if (strobe.capInst) begin
      iLineQ  <= missInstAddr[ADDR_W-1:LINE_OFF];
      iLatQ   <= latSat;
      iValidQ <= 1'b1;
    end else if (strobe.clrInst) begin
      iValidQ <= 1'b0;
    end
  end

  assign dataAddr = dAddrQ;
  assign dataLat  = dLatQ;
  assign dataIp   = {dBundleQ, dSlotQ, 1'b0, dValidQ};
  assign instLine = {iLineQ, {(LINE_OFF-1){1'b0}}, iValidQ};
  assign instLat  = iLatQ;

endmodule

// File: rtl/miss_addr_capture.sv
module miss_addr_capture
  import miss_cap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned MEAS_W   = 16,
  parameter int unsigned LAT_W    = 12,
  parameter int unsigned LINE_OFF = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic              missIsHit,
  input  logic              missKind,
  input  logic [ADDR_W-1:0] missInstAddr,
  input  logic [1:0]        missSlot,
  input  logic [ADDR_W-1:0] missDataAddr,
  input  logic [MEAS_W-1:0] missLatency,
  input  logic              dataCapEn,
  input  logic              instCapEn,
  input  logic [3:0]        dataThrSel,
  input  logic [3:0]        instThrSel,
  input  logic              clrData,
  input  logic              clrInst,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [LAT_W-1:0]  dataLat,
  output logic [ADDR_W-1:0] dataIp,
  output logic [ADDR_W-1:0] instLine,
  output logic [LAT_W-1:0]  instLat,
  output logic              dataEvent,
  output logic              instEvent
);

  mcap_strobe_t strobe;

  mcap_ctrl #(.MEAS_W(MEAS_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .missIsHit   (missIsHit),
    .missKind    (missKind),
    .missLatency (missLatency),
    .dataCapEn   (dataCapEn),
    .instCapEn   (instCapEn),
    .dataThrSel  (dataThrSel),
    .instThrSel  (instThrSel),
    .clrData     (clrData),
    .clrInst     (clrInst),
    .strobe      (strobe),
    .dataEvent   (dataEvent),
    .instEvent   (instEvent)
  );

  mcap_datapath #(
    .ADDR_W   (ADDR_W),
    .MEAS_W   (MEAS_W),
    .LAT_W    (LAT_W),
    .LINE_OFF (LINE_OFF)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .missInstAddr (missInstAddr),
    .missSlot     (missSlot),
    .missDataAddr (missDataAddr),
    .missLatency  (missLatency),
    .dataAddr     (dataAddr),
    .dataLat      (dataLat),
    .dataIp       (dataIp),
    .instLine     (instLine),
    .instLat      (instLat)
  );

endmodule

// File: rtl/mcap_checker.sv
module mcap_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MEAS_W = 16,
  parameter int unsigned LAT_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              missIsHit,
  input logic              missKind,
  input logic [MEAS_W-1:0] missLatency,
  input logic              clrData,
  input logic              clrInst,
  input logic [ADDR_W-1:0] dataAddr,
  input logic [LAT_W-1:0]  dataLat,
  input logic [ADDR_W-1:0] dataIp,
  input logic [ADDR_W-1:0] instLine,
  input logic [LAT_W-1:0]  instLat,
  input logic              dataEvent,
  input logic              instEvent
);

  localparam logic [LAT_W-1:0] LAT_TOP = '1;

  // R2: a hit leaves every recorded field alone
  a_r2_hit_no_update: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missIsHit) |=> ($stable(dataAddr) && $stable(dataLat) &&
                                  $stable(instLine[ADDR_W-1:1]) && $stable(instLat) &&
                                  !dataEvent && !instEvent));

  // R8: a data event follows only a data miss
  a_r8_data_event_src: assert property (@(posedge clk) disable iff (!rstN)
    dataEvent |-> ($past(missValid) && !$past(missIsHit) && !$past(missKind)));

  // R8: an instruction event follows only an instruction miss
  a_r8_inst_event_src: assert property (@(posedge clk) disable iff (!rstN)
    instEvent |-> ($past(missValid) && !$past(missIsHit) && $past(missKind)));

  // R10: a capture leaves the valid flag set
  a_r10_valid_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    (dataEvent |-> dataIp[0]) and (instEvent |-> instLine[0]));

  // R10: a clear without a capture drops the valid flag
  a_r10_clear_data: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clrData) && !dataEvent) |-> !dataIp[0]);

  a_r10_clear_inst: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clrInst) && !instEvent) |-> !instLine[0]);

  // R11: stored latency equals the saturated measured value
  a_r11_lat_saturate: assert property (@(posedge clk) disable iff (!rstN)
    dataEvent |-> (dataLat == (($past(missLatency) > MEAS_W'(LAT_TOP)) ?
                               LAT_TOP : $past(missLatency[LAT_W-1:0]))));

  // R7: an instruction capture leaves the data record untouched
  a_r7_no_crosstalk: assert property (@(posedge clk) disable iff (!rstN)
    instEvent |-> ($stable(dataAddr) && $stable(dataLat)));

endmodule

bind miss_addr_capture mcap_checker #(
  .ADDR_W (ADDR_W),
  .MEAS_W (MEAS_W),
  .LAT_W  (LAT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .missValid   (missValid),
  .missIsHit   (missIsHit),
  .missKind    (missKind),
  .missLatency (missLatency),
  .clrData     (clrData),
  .clrInst     (clrInst),
  .dataAddr    (dataAddr),
  .dataLat     (dataLat),
  .dataIp      (dataIp),
  .instLine    (instLine),
  .instLat     (instLat),
  .dataEvent   (dataEvent),
  .instEvent   (instEvent)
);

// File: tb/sim_miss_addr_capture.sv
module sim_miss_addr_capture;

  localparam int ADDR_W = 32;
  localparam int MEAS_W = 16;
  localparam int LAT_W  = 12;
  localparam int NVEC   = 11;

  logic              clk = 1'b0;
  logic              rstN;
  logic              missValid, missIsHit, missKind;
  logic [ADDR_W-1:0] missInstAddr, missDataAddr;
  logic [1:0]        missSlot;
  logic [MEAS_W-1:0] missLatency;
  logic              dataCapEn, instCapEn, clrData, clrInst;
  logic [3:0]        dataThrSel, instThrSel;
  logic [ADDR_W-1:0] dataAddr, dataIp, instLine;
  logic [LAT_W-1:0]  dataLat, instLat;
  logic              dataEvent, instEvent;

  int nVec = 0;
  int nBad = 0;

  logic [ADDR_W-1:0] eDataAddr, eDataIp, eInstLine;
  logic [LAT_W-1:0]  eDataLat, eInstLat;

  // {kind, hit, sel, latency, expected capture}
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'd0,  16'd0,    1'b1},  // R4 any latency
    {1'b0, 1'b1, 4'd0,  16'd50,   1'b0},  // R2 hit ignored
    {1'b0, 1'b0, 4'd3,  16'd15,   1'b0},  // R3 below 16
    {1'b0, 1'b0, 4'd3,  16'd16,   1'b1},  // R3 at 16
    {1'b0, 1'b0, 4'd11, 16'd4095, 1'b0},  // R3 below 4096
    {1'b0, 1'b0, 4'd11, 16'd5000, 1'b1},  // R11 saturate
    {1'b1, 1'b0, 4'd1,  16'd3,    1'b0},  // R3 below 4
    {1'b1, 1'b0, 4'd1,  16'd4,    1'b1},  // R7 capture
    {1'b1, 1'b1, 4'd0,  16'd9,    1'b0},  // R2 inst hit
    {1'b0, 1'b0, 4'd15, 16'd4096, 1'b1},  // R3 code 15
    {1'b1, 1'b0, 4'd2,  16'd4095, 1'b1}   // R9 overwrite
  };

  miss_addr_capture u0 (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missIsHit(missIsHit),
    .missKind(missKind), .missInstAddr(missInstAddr), .missSlot(missSlot),
    .missDataAddr(missDataAddr), .missLatency(missLatency),
    .dataCapEn(dataCapEn), .instCapEn(instCapEn),
    .dataThrSel(dataThrSel), .instThrSel(instThrSel),
    .clrData(clrData), .clrInst(clrInst),
    .dataAddr(dataAddr), .dataLat(dataLat), .dataIp(dataIp),
    .instLine(instLine), .instLat(instLat),
    .dataEvent(dataEvent), .instEvent(instEvent)
  );

  always #10 clk = ~clk;

  initial begin
    #3_000_000;
    nBad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    check({tag, " dataAddr"}, 64'(dataAddr), 64'(eDataAddr));
    check({tag, " dataLat"},  64'(dataLat),  64'(eDataLat));
    check({tag, " dataIp"},   64'(dataIp),   64'(eDataIp));
    check({tag, " instLine"}, 64'(instLine), 64'(eInstLine));
    check({tag, " instLat"},  64'(instLat),  64'(eInstLat));
  endtask

  function automatic logic [LAT_W-1:0] satLat(input logic [MEAS_W-1:0] l);
    return (l > 16'd4095) ? 12'hfff : l[LAT_W-1:0];
  endfunction

  // drive at a falling edge, capture at the rising edge, check at the next falling edge
  task automatic applyMiss(input logic kind, input logic hit, input logic [MEAS_W-1:0] lat,
                           input logic [ADDR_W-1:0] ia, input logic [1:0] slot,
                           input logic [ADDR_W-1:0] da);
    missValid = 1'b1; missKind = kind; missIsHit = hit; missLatency = lat;
    missInstAddr = ia; missSlot = slot; missDataAddr = da;
    @(negedge clk);
    missValid = 1'b0;
  endtask

  task automatic recordData(input logic [MEAS_W-1:0] lat, input logic [ADDR_W-1:0] ia,
                            input logic [1:0] slot, input logic [ADDR_W-1:0] da);
    eDataAddr = da;
    eDataLat  = satLat(lat);
    eDataIp   = {ia[ADDR_W-1:4], slot, 1'b0, 1'b1};
  endtask

  task automatic recordInst(input logic [MEAS_W-1:0] lat, input logic [ADDR_W-1:0] ia);
    eInstLine = {ia[ADDR_W-1:5], 4'b0, 1'b1};
    eInstLat  = satLat(lat);
  endtask

  initial begin
    rstN = 1'b0; missValid = 1'b0; missIsHit = 1'b0; missKind = 1'b0;
    missInstAddr = '0; missSlot = '0; missDataAddr = '0; missLatency = '0;
    dataCapEn = 1'b1; instCapEn = 1'b1; clrData = 1'b0; clrInst = 1'b0;
    dataThrSel = '0; instThrSel = '0;
    eDataAddr = '0; eDataLat = '0; eDataIp = '0; eInstLine = '0; eInstLat = '0;
    repeat (3) @(negedge clk);

    // R1 reset state
    checkRegs("R1 reset");
    check("R1 dataEvent", 64'(dataEvent), 64'd0);
    check("R1 instEvent", 64'(instEvent), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkRegs("R1 after release");

    for (int i = 0; i < NVEC; i++) begin
      logic              vKind, vHit, vExp;
      logic [3:0]        vSel;
      logic [MEAS_W-1:0] vLat;
      logic [ADDR_W-1:0] ia, da;
      logic [1:0]        slot;
      {vKind, vHit, vSel, vLat, vExp} = VEC[i];
      ia   = 32'h1000_0000 + (32'(i) << 8) + 32'h17;
      da   = 32'h8000_0000 + 32'(i) * 32'h44;
      slot = 2'(i % 3);
      dataThrSel = vSel; instThrSel = vSel;
      applyMiss(vKind, vHit, vLat, ia, slot, da);
      if (vExp && !vKind) recordData(vLat, ia, slot, da);
      if (vExp && vKind)  recordInst(vLat, ia);
      // R8 event pulse per channel, R5 R6 R7 R9 R11 record contents
      check($sformatf("R8 vec%0d dataEvent", i), 64'(dataEvent), 64'(vExp & !vKind));
      check($sformatf("R8 vec%0d instEvent", i), 64'(instEvent), 64'(vExp & vKind));
      checkRegs($sformatf("R5 R6 R7 vec%0d", i));
    end

    // R8 pulse lasts one cycle
    dataThrSel = 4'd0; instThrSel = 4'd0;
    applyMiss(1'b0, 1'b0, 16'd7, 32'h2222_3338, 2'd2, 32'hCAFE_0010);
    recordData(16'd7, 32'h2222_3338, 2'd2, 32'hCAFE_0010);
    check("R8 pulse high", 64'(dataEvent), 64'd1);
    checkRegs("R6 slot two");
    @(negedge clk);
    check("R8 pulse low next cycle", 64'(dataEvent), 64'd0);

    // R10 clear valid alone
    clrData = 1'b1; @(negedge clk); clrData = 1'b0;
    eDataIp[0] = 1'b0;
    checkRegs("R10 data clear");
    clrInst = 1'b1; @(negedge clk); clrInst = 1'b0;
    eInstLine[0] = 1'b0;
    checkRegs("R10 inst clear");

    // R10 capture wins over clear on the same edge
    clrData = 1'b1;
    applyMiss(1'b0, 1'b0, 16'd30, 32'h3333_4440, 2'd1, 32'hBEEF_0020);
    clrData = 1'b0;
    recordData(16'd30, 32'h3333_4440, 2'd1, 32'hBEEF_0020);
    checkRegs("R10 capture beats clear");

    // R2 channel disabled
    dataCapEn = 1'b0;
    applyMiss(1'b0, 1'b0, 16'd100, 32'h4444_0000, 2'd0, 32'h1234_5678);
    check("R2 disabled no event", 64'(dataEvent), 64'd0);
    checkRegs("R2 disabled no update");
    dataCapEn = 1'b1;
    instCapEn = 1'b0;
    applyMiss(1'b1, 1'b0, 16'd100, 32'h5555_0000, 2'd0, 32'h0);
    check("R2 inst disabled no event", 64'(instEvent), 64'd0);
    checkRegs("R2 inst disabled no update");
    instCapEn = 1'b1;

    // R1 reset mid-run clears everything
    rstN = 1'b0; @(negedge clk);
    eDataAddr = '0; eDataLat = '0; eDataIp = '0; eInstLine = '0; eInstLat = '0;
    checkRegs("R1 mid-run reset");
    rstN = 1'b1; @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule